// File: doc/BRIEF.md
# Interrupt acceptance and cause register

This block keeps the processor's exception-cause state and decides, cycle by cycle, whether an interrupt exception is taken. It runs in one of two modes. In line mode, individual request lines and two software-owned request bits are each gated by a mask bit, and any surviving request triggers an interrupt. In controller mode, an external interrupt controller presents a priority level as an unsigned number. An interrupt is taken when that level is strictly above the priority the core is currently running at. The pending field then keeps a snapshot of the level that won.

Controller mode needs two things: the hardware must declare itself capable, and software must enable vectored interrupts. The mode is registered, so a change takes effect one cycle later. When an interrupt is taken, a one-cycle strobe rises. On that same edge the exception code becomes zero and, in controller mode, the level snapshot is stored. Any other exception source loads its own 5-bit code through a load port, for example 8 for a system call, 9 for a breakpoint, 10 for a reserved instruction and 12 for an overflow. Software can write only the two low pending bits.

Top module: `irq_cause_ctrl`

## Requirements
- R1: While reset is asserted, `pend_field`, `exc_code`, `take_irq` and `ctl_mode` are all zero, so the block starts in line mode.
- R2: `ctl_mode` becomes 1 one cycle after both `ctl_capable` and `vec_enable` are 1, and returns to 0 one cycle after either of them drops. A decision uses the registered mode.
- R3: In controller mode, an interrupt is decided when `ext_level > run_level` as unsigned values, `glob_ie` is 1 and `exc_level` is 0. Equal levels never qualify. `take_irq` is 1 in the cycle after the decision.
- R4: In controller mode, an `ext_level` of zero never causes an interrupt on its own.
- R5: In controller mode, the edge that raises `take_irq` stores `ext_level` into `pend_field[2 +: IPL_W]`, and the bits above it read zero. Until the next take, those bits hold and do not follow `ext_level`.
- R6: A software write (`sw_wr_en`) updates `pend_field[1:0]` to `sw_wr_data[1:0]` on the next edge, and reads return exactly that value. Write data on bits 2 and up has no effect, and no software write ever changes `exc_code`.
- R7: Software pending bit i (i = 0, 1) requests an interrupt only while `irq_mask[i]` is 1, in both modes.
- R8: In line mode, `pend_field[2+i]` shows `hw_req[i]` registered. An interrupt is decided when a bit of {`hw_req`, software bits} ANDed with `irq_mask` is 1, `glob_ie` is 1 and `exc_level` is 0.
- R9: `take_irq` is never 1 in two consecutive cycles. A decision in the cycle right after a take is suppressed.
- R10: The edge that raises `take_irq` sets `exc_code` to 0, the interrupt code. Otherwise `exc_load` loads `exc_code_in` on the next edge. An interrupt on the same edge as a load takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_capable | input | 1 | Hardware supports controller-driven interrupts |
| vec_enable | input | 1 | Software enable for vectored interrupts |
| ext_level | input | IPL_W | Priority level presented by the interrupt controller |
| run_level | input | IPL_W | Priority level the core currently runs at |
| hw_req | input | NUM_HW_LINES | Per-line hardware requests (line mode) |
| irq_mask | input | NUM_HW_LINES+2 | Mask, one bit per pending bit |
| glob_ie | input | 1 | Global interrupt enable |
| exc_level | input | 1 | Core is already handling an exception |
| sw_wr_en | input | 1 | Software write strobe for the pending field |
| sw_wr_data | input | NUM_HW_LINES+2 | Software write data; only bits 1:0 are used |
| exc_load | input | 1 | Another exception source loads a code |
| exc_code_in | input | 5 | Code from the other exception source |
| take_irq | output | 1 | One-cycle interrupt-taken strobe |
| ctl_mode | output | 1 | Registered mode, 1 for controller mode |
| pend_field | output | NUM_HW_LINES+2 | Pending bits, or the level snapshot in bits 2 and up |
| exc_code | output | 5 | Exception code |

## Verification
The bench builds the block with six hardware lines and a four-bit priority level. The level is narrower than the hardware part of the pending field, so the zero-padding branch is elaborated, and the two bits above the snapshot can be shown to read zero after a take. Level values 5 and 9 cross the nibble boundary of the field. A snapshot taken while only a software bit requests shows that a zero level is stored. The level comparison is checked on equal levels and on a level that is greater.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int CODE_W = 5;
   localparam int SW_BITS = 2;
   typedef logic [CODE_W-1:0] exc_code_t;
   localparam exc_code_t CODE_INT  = 5'd0;
   localparam exc_code_t CODE_SYS  = 5'd8;
   localparam exc_code_t CODE_BRK  = 5'd9;
   localparam exc_code_t CODE_RSVD = 5'd10;
   localparam exc_code_t CODE_OVF  = 5'd12;
endpackage

// File: rtl/irq_sw_pend.sv
module irq_sw_pend #(
   parameter int BITS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [BITS-1:0] wr_data,
   output logic [BITS-1:0] sw_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     sw_q <= '0;
      else if (wr_en) sw_q <= wr_data;
   end

   assert_sw_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> sw_q == $past(wr_data));
endmodule

// File: rtl/irq_line_arb.sv
module irq_line_arb #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] req,
   input  logic [WIDTH-1:0] mask,
   output logic             hit
);
   logic [WIDTH-1:0] gated;
   for (genvar i = 0; i < WIDTH; i++) begin : g_gate
      assign gated[i] = req[i] & mask[i];
   end
   assign hit = |gated;
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
   parameter int IPL_W = 6
) (
   input  logic [IPL_W-1:0] presented,
   input  logic [IPL_W-1:0] running,
   output logic             above
);
   assign above = presented > running;

   always_comb begin
      assert_zero_never_above_R4: assert (!(above && presented == '0));
   end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
   import irq_pkg::*;
#(
   parameter int NUM_HW_LINES = 6,
   parameter int IPL_W        = 6,
   localparam int PEND_W      = NUM_HW_LINES + SW_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_capable,
   input  logic              vec_enable,
   input  logic [IPL_W-1:0]  ext_level,
   input  logic [IPL_W-1:0]  run_level,
   input  logic [NUM_HW_LINES-1:0] hw_req,
   input  logic [PEND_W-1:0] irq_mask,
   input  logic              glob_ie,
   input  logic              exc_level,
   input  logic              sw_wr_en,
   input  logic [PEND_W-1:0] sw_wr_data,
   input  logic              exc_load,
   input  logic [CODE_W-1:0] exc_code_in,
   output logic              take_irq,
   output logic              ctl_mode,
   output logic [PEND_W-1:0] pend_field,
   output logic [CODE_W-1:0] exc_code
);
   if (IPL_W < 1 || IPL_W > NUM_HW_LINES) begin : g_bad_ipl
      $error("IPL_W must be between 1 and NUM_HW_LINES");
   end
   if (NUM_HW_LINES < 1) begin : g_bad_lines
      $error("NUM_HW_LINES must be at least 1");
   end

   logic                    mode_q;
   logic                    take_q;
   logic [NUM_HW_LINES-1:0] hw_q;
   exc_code_t               code_q;
   logic [SW_BITS-1:0]      sw_q;
   logic                    sw_hit, line_hit, lvl_above;
   logic                    want, decide;
   logic [NUM_HW_LINES-1:0] snap_ext;

   irq_sw_pend #(.BITS(SW_BITS)) u_sw (
      .clk(clk), .rst_n(rst_n), .wr_en(sw_wr_en),
      .wr_data(sw_wr_data[SW_BITS-1:0]), .sw_q(sw_q));

   irq_line_arb #(.WIDTH(SW_BITS)) u_sw_arb (
      .req(sw_q), .mask(irq_mask[SW_BITS-1:0]), .hit(sw_hit));

   irq_line_arb #(.WIDTH(NUM_HW_LINES)) u_hw_arb (
      .req(hw_req), .mask(irq_mask[PEND_W-1:SW_BITS]), .hit(line_hit));

   irq_level_cmp #(.IPL_W(IPL_W)) u_cmp (
      .presented(ext_level), .running(run_level), .above(lvl_above));

   if (IPL_W < NUM_HW_LINES) begin : g_pad
      assign snap_ext = {{(NUM_HW_LINES-IPL_W){1'b0}}, ext_level};
   end else begin : g_full
      assign snap_ext = ext_level;
   end

   always_comb begin
      if (mode_q) want = lvl_above | sw_hit;
      else        want = line_hit  | sw_hit;
      decide = want & glob_ie & ~exc_level & ~take_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         take_q <= 1'b0;
         hw_q   <= '0;
         code_q <= CODE_INT;
      end else begin
         mode_q <= ctl_capable & vec_enable;
         take_q <= decide;
         if (mode_q) begin
            if (decide) hw_q <= snap_ext;
         end else begin
            hw_q <= hw_req;
         end
         if (decide)        code_q <= CODE_INT;
         else if (exc_load) code_q <= exc_code_in;
      end
   end

   assign take_irq   = take_q;
   assign ctl_mode   = mode_q;
   assign pend_field = {hw_q, sw_q};
   assign exc_code   = code_q;

   assert_take_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |=> !take_irq);
   assert_take_code_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> exc_code == CODE_INT);
   assert_load_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_load && !decide) |=> exc_code == $past(exc_code_in));
   assert_zero_level_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && ext_level == '0 && !sw_hit) |=> !take_irq);
   assert_snapshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !decide) |=> $stable(pend_field[PEND_W-1:SW_BITS]));
   assert_blocked_in_exc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_level |=> !take_irq);
endmodule

// File: tb/tb_irq_cause_ctrl.sv
module tb_irq_cause_ctrl;
   localparam int NHW = 6;
   localparam int IPW = 4;
   localparam int PW  = NHW + 2;

   typedef struct {
      logic          take;
      logic          mode;
      logic [PW-1:0] pend;
      logic [4:0]    code;
      string         req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_capable = 0, vec_enable = 0, glob_ie = 0, exc_level = 0;
   logic sw_wr_en = 0, exc_load = 0;
   logic [IPW-1:0] ext_level = '0, run_level = '0;
   logic [NHW-1:0] hw_req = '0;
   logic [PW-1:0]  irq_mask = '0, sw_wr_data = '0;
   logic [4:0]     exc_code_in = '0;
   logic           take_irq, ctl_mode;
   logic [PW-1:0]  pend_field;
   logic [4:0]     exc_code;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   exp_t sb[$];

   always #5 clk = ~clk;

   irq_cause_ctrl #(.NUM_HW_LINES(NHW), .IPL_W(IPW)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_capable(ctl_capable), .vec_enable(vec_enable),
      .ext_level(ext_level), .run_level(run_level), .hw_req(hw_req),
      .irq_mask(irq_mask), .glob_ie(glob_ie), .exc_level(exc_level),
      .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .exc_load(exc_load),
      .exc_code_in(exc_code_in), .take_irq(take_irq), .ctl_mode(ctl_mode),
      .pend_field(pend_field), .exc_code(exc_code));

   // monitor: compares outputs against the queued expectation
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (take_irq !== e.take || ctl_mode !== e.mode ||
             pend_field !== e.pend || exc_code !== e.code) begin
            failures++;
            $display("FAIL %s: take=%0b mode=%0b pend=%h code=%0d expected take=%0b mode=%0b pend=%h code=%0d",
                     e.req, take_irq, ctl_mode, pend_field, exc_code,
                     e.take, e.mode, e.pend, e.code);
         end
      end
   end

   // driver: one clock edge, then queue what that edge must produce
   task automatic step(input logic t, input logic m, input logic [PW-1:0] p,
                       input logic [4:0] c, input string r);
      exp_t e;
      @(posedge clk);
      e.take = t; e.mode = m; e.pend = p; e.code = c; e.req = r;
      sb.push_back(e);
      @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      step(0, 0, 8'h00, 5'd0, "R1 reset");
      step(0, 0, 8'h00, 5'd0, "R1 reset hold");
      rst_n = 1; glob_ie = 1; irq_mask = 8'hFF;

      // line mode
      hw_req = 6'b000100;
      step(1, 0, 8'h10, 5'd0, "R8 line request taken");
      step(0, 0, 8'h10, 5'd0, "R9 no back-to-back take");
      hw_req = '0;
      step(0, 0, 8'h00, 5'd0, "R8 request gone");
      hw_req = 6'b000001; irq_mask = 8'hFB;
      step(0, 0, 8'h04, 5'd0, "R8 masked line ignored");
      irq_mask = 8'hFF; exc_level = 1;
      step(0, 0, 8'h04, 5'd0, "R8 blocked in exception");
      exc_level = 0; hw_req = '0;
      sw_wr_en = 1; sw_wr_data = 8'hFD; irq_mask = 8'hFC;
      step(0, 0, 8'h01, 5'd0, "R6 sw write low bits only");
      sw_wr_en = 0;
      step(0, 0, 8'h01, 5'd0, "R7 masked sw bit line mode");
      irq_mask = 8'hFF;
      step(1, 0, 8'h01, 5'd0, "R7 unmasked sw bit line mode");
      sw_wr_en = 1; sw_wr_data = 8'h00;
      step(0, 0, 8'h00, 5'd0, "R6 sw clear");
      sw_wr_en = 0;
      step(0, 0, 8'h00, 5'd0, "R6 sw clear hold");
      exc_load = 1; exc_code_in = 5'd9;
      step(0, 0, 8'h00, 5'd9, "R10 breakpoint code load");
      exc_load = 0;

      // mode selection
      ctl_capable = 1;
      step(0, 0, 8'h00, 5'd9, "R2 capable alone");
      vec_enable = 1;
      step(0, 1, 8'h00, 5'd9, "R2 controller mode entered");

      // controller mode
      step(0, 1, 8'h00, 5'd9, "R4 zero level no take");
      ext_level = 4'd5; run_level = 4'd5;
      step(0, 1, 8'h00, 5'd9, "R3 equal level no take");
      run_level = 4'd3;
      step(1, 1, 8'h14, 5'd0, "R3 R5 higher level taken with snapshot");
      ext_level = 4'd2; run_level = 4'd7;
      step(0, 1, 8'h14, 5'd0, "R5 snapshot held");
      sw_wr_en = 1; sw_wr_data = 8'hFE; irq_mask = 8'hFC;
      step(0, 1, 8'h16, 5'd0, "R6 upper write ignored");
      sw_wr_en = 0; ext_level = 4'd9; run_level = 4'd1;
      exc_load = 1; exc_code_in = 5'd12;
      step(1, 1, 8'h26, 5'd0, "R10 interrupt wins over load");
      exc_load = 0; ext_level = 4'd0;
      step(0, 1, 8'h26, 5'd0, "R9 R5 quiet after take");
      irq_mask = 8'hFF;
      step(1, 1, 8'h02, 5'd0, "R7 sw bit in controller mode");
      irq_mask = 8'hFC;
      step(0, 1, 8'h02, 5'd0, "R7 masked sw bit controller mode");
      exc_load = 1; exc_code_in = 5'd8;
      step(0, 1, 8'h02, 5'd8, "R10 syscall code load");
      exc_load = 0; vec_enable = 0;
      step(0, 0, 8'h02, 5'd8, "R2 controller mode left");
      step(0, 0, 8'h02, 5'd8, "R2 line mode again");

      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule